// File: doc/BRIEF.md
# Dual-Match Prescaled Timer

A byte-wide peripheral holding a 10-bit up-counter and two independent compare channels. Software programs it through an 8-bit bus with a 4-bit offset, a write strobe and a read strobe. The counter advances once per selected tick. A tick comes from one of three sources: the peripheral clock divided by 2, the peripheral clock divided by 16, or a tick pulse from a neighbouring timer. The counter wraps from 1023 to 0.

Each compare channel has a 10-bit target. Software writes the target in two steps: first a high byte whose bits 7:6 carry the top two bits, then a low byte that commits the whole value. When the count steps onto a target, a sticky flag is raised. Reading the status register returns the flags and clears them. Writing 1s to the same bit positions stores per-channel interrupt enables. The enables are kept apart from the flags. The interrupt request goes out together with a 2-bit priority level. Priority 0 silences the request.

Software reads the count high register first and the count low register second. The low register returns a copy taken at the moment of the high read, so a 10-bit value is read coherently.

Top module: `dual_match_timer`

## Requirements
- R1: After reset, the status register (offset 0x0) reads 0, both count registers (0xE, 0xF) read 0, and irqReq is low.
- R2: Status bit 0 is the run enable. While it is 0 the count does not change, and the prescaler restarts from zero.
- R3: With control bits 3:2 = 00, the count advances exactly once every 2 clock cycles while enabled.
- R4: With control bits 3:2 = 01, the count advances once for each clock cycle in which cascadeTick is high, and does not advance otherwise.
- R5: With control bits 3:2 = 1x, the count advances exactly once every 16 clock cycles while enabled.
- R6: The count steps from 1023 to 0.
- R7: Status bit 1 (channel 1) or bit 2 (channel 2) becomes 1 on the tick that makes the count equal to that channel's target. The flag stays 1 until it is cleared.
- R8: Any read of offset 0x0 returns the flags as they were, then clears them. A match in the same cycle as the read leaves its flag set.
- R9: Writing offset 0x0 stores bit 0 as the run enable and bits 2:1 as the channel 2/1 interrupt enables. A write never sets a flag.
- R10: Offsets 0x2/0x4 store bits 7:6 as the pending top bits of target 1/2 and leave the active target unchanged. Offsets 0x3/0x5 load the active target from those pending bits and the written low byte.
- R11: A read of 0xE returns count bits 9:8 in data bits 7:6 (bits 5:0 zero) and captures count bits 7:0. Reads of 0xF return that capture.
- R12: irqReq is high exactly when control bits 1:0 are nonzero and some channel has both its flag and its enable set. irqLevel always equals control bits 1:0.
- R13: The control register (0x1), the target registers and all unassigned offsets read as 0. busRdata is 0 when busRd is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Peripheral clock |
| rstN | input | 1 | Asynchronous active-low reset |
| busAddr | input | 4 | Register offset |
| busWr | input | 1 | Write strobe, one cycle per write |
| busRd | input | 1 | Read strobe, one cycle per read |
| busWdata | input | 8 | Write data |
| busRdata | output | 8 | Read data, valid in the cycle of busRd |
| cascadeTick | input | 1 | Tick from neighbouring timer |
| irqReq | output | 1 | Interrupt request |
| irqLevel | output | 2 | Priority of the request |

## Verification
The assertions check the following on every cycle:
- The count moves by exactly one per tick and holds while disabled.
- Divide-by-2 ticks are never back to back.
- A match always raises its flag.
- A status read clears the flags unless a match coincides.
- Status writes never raise a flag.
- A low-byte write lands in the active target.
- A high-count read captures the low byte.

Only the bench's scenarios can show the other properties:
- The exact tick rate of each source over a window.
- The wrap at 1023.
- A pending high byte staying inert until its low byte arrives.
- The coherent two-register count read.
- The interrupt request following priority changes.

// File: rtl/tmr_pkg.sv
`timescale 1ns/1ps
package tmr_pkg;
  localparam int BUS_AW    = 4;
  localparam int NUM_MATCH = 2;

  localparam logic [BUS_AW-1:0] OFS_STATUS = 4'h0;
  localparam logic [BUS_AW-1:0] OFS_CTRL   = 4'h1;
  localparam logic [BUS_AW-1:0] OFS_TGT0   = 4'h2;  // channel i: high at OFS_TGT0+2i, low one above
  localparam logic [BUS_AW-1:0] OFS_CNTHI  = 4'hE;
  localparam logic [BUS_AW-1:0] OFS_CNTLO  = 4'hF;

  typedef enum logic [1:0] {
    SRC_DIV2    = 2'd0,
    SRC_CASCADE = 2'd1,
    SRC_SLOW    = 2'd2
  } cntSrc_t;

  // strobes from control to datapath
  typedef struct packed {
    logic [NUM_MATCH-1:0] wrHi;
    logic [NUM_MATCH-1:0] wrLo;
    logic                 snapLo;
  } dpStrb_t;
endpackage

// File: rtl/tmr_datapath.sv
`timescale 1ns/1ps
module tmr_datapath
  import tmr_pkg::*;
#(
  parameter int CNT_W  = 10,
  parameter int DATA_W = 8,
  parameter int PRE_W  = 4
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  dpStrb_t              strb,
  input  logic [DATA_W-1:0]    busWdata,
  input  logic                 cntEn,
  input  cntSrc_t              cntSrc,
  input  logic                 cascadeTick,
  output logic [NUM_MATCH-1:0] hit,
  output logic [CNT_W-DATA_W-1:0] cntHi,
  output logic [DATA_W-1:0]    cntSnap
);
  localparam int HI_W = CNT_W - DATA_W;

  logic [PRE_W-1:0] pre;
  logic             tick;
  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] cntNext;

  // prescaler runs only while enabled, restarts from zero otherwise
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)      pre <= '0;
    else if (cntEn) pre <= pre + 1'b1;
    else            pre <= '0;
  end

  always_comb begin
    unique case (cntSrc)
      SRC_DIV2:    tick = cntEn && pre[0];
      SRC_CASCADE: tick = cntEn && cascadeTick;
      default:     tick = cntEn && (&pre);
    endcase
  end

  assign cntNext = cnt + 1'b1;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)     cnt <= '0;
    else if (tick) cnt <= cntNext;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)            cntSnap <= '0;
    else if (strb.snapLo) cntSnap <= cnt[DATA_W-1:0];
  end

  assign cntHi = cnt[CNT_W-1 -: HI_W];

  for (genvar i = 0; i < NUM_MATCH; i++) begin : g_chan
    logic [HI_W-1:0]  pendHi;
    logic [CNT_W-1:0] target;

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        pendHi <= '0;
        target <= '0;
      end else begin
        if (strb.wrHi[i]) pendHi <= busWdata[DATA_W-1 -: HI_W];
        if (strb.wrLo[i]) target <= {pendHi, busWdata};
      end
    end

    assign hit[i] = tick && (cntNext == target);

    // R10: low-byte write lands in the active target
    p_target_load_r10: assert property (@(posedge clk) disable iff (!rstN)
      strb.wrLo[i] |=> target[DATA_W-1:0] == $past(busWdata));
  end

  // R2: no movement without enable
  p_hold_disabled_r2: assert property (@(posedge clk) disable iff (!rstN)
    !cntEn |=> cnt == $past(cnt));

  // R6: each tick moves the count by exactly one, modulo 2^CNT_W
  p_single_step_r6: assert property (@(posedge clk) disable iff (!rstN)
    tick |=> cnt == CNT_W'($past(cnt) + 1'b1));

  // R3: divide-by-2 ticks never come back to back
  p_div2_spacing_r3: assert property (@(posedge clk) disable iff (!rstN)
    (tick && cntSrc == SRC_DIV2) |=> !(tick && cntSrc == SRC_DIV2));

  // R11: high read captures the low byte
  p_snap_capture_r11: assert property (@(posedge clk) disable iff (!rstN)
    strb.snapLo |=> cntSnap == $past(cnt[DATA_W-1:0]));
endmodule

// File: rtl/tmr_ctrl.sv
`timescale 1ns/1ps
module tmr_ctrl
  import tmr_pkg::*;
#(
  parameter int CNT_W  = 10,
  parameter int DATA_W = 8
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [BUS_AW-1:0]    busAddr,
  input  logic                 busWr,
  input  logic                 busRd,
  input  logic [DATA_W-1:0]    busWdata,
  input  logic [NUM_MATCH-1:0] hit,
  input  logic [CNT_W-DATA_W-1:0] cntHi,
  input  logic [DATA_W-1:0]    cntSnap,
  output dpStrb_t              strb,
  output logic                 cntEn,
  output cntSrc_t              cntSrc,
  output logic [DATA_W-1:0]    busRdata,
  output logic                 irqReq,
  output logic [1:0]           irqLevel
);
  localparam int HI_W = CNT_W - DATA_W;

  logic                 wrStatus, wrCtrl, rdStatus, rdCntHi;
  logic [NUM_MATCH-1:0] wrHiV, wrLoV;
  logic [NUM_MATCH-1:0] flag, intEn;
  logic [1:0]           srcBits, prio;
  logic                 runOn;

  assign wrStatus = busWr && (busAddr == OFS_STATUS);
  assign wrCtrl   = busWr && (busAddr == OFS_CTRL);
  assign rdStatus = busRd && (busAddr == OFS_STATUS);
  assign rdCntHi  = busRd && (busAddr == OFS_CNTHI);

  for (genvar i = 0; i < NUM_MATCH; i++) begin : g_dec
    assign wrHiV[i] = busWr && (busAddr == OFS_TGT0 + BUS_AW'(2*i));
    assign wrLoV[i] = busWr && (busAddr == OFS_TGT0 + BUS_AW'(2*i+1));
  end

  assign strb = '{wrHi: wrHiV, wrLo: wrLoV, snapLo: rdCntHi};

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      runOn   <= 1'b0;
      intEn   <= '0;
      srcBits <= '0;
      prio    <= '0;
    end else begin
      if (wrStatus) begin
        runOn <= busWdata[0];
        intEn <= busWdata[NUM_MATCH:1];
      end
      if (wrCtrl) begin
        srcBits <= busWdata[3:2];
        prio    <= busWdata[1:0];
      end
    end
  end

  // a match wins over a clearing read in the same cycle
  for (genvar i = 0; i < NUM_MATCH; i++) begin : g_flag
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)         flag[i] <= 1'b0;
      else if (hit[i])   flag[i] <= 1'b1;
      else if (rdStatus) flag[i] <= 1'b0;
    end

    // R7: a match always raises its flag
    p_match_sets_r7: assert property (@(posedge clk) disable iff (!rstN)
      hit[i] |=> flag[i]);
    // R8: status read clears a flag unless a match coincides
    p_read_clears_r8: assert property (@(posedge clk) disable iff (!rstN)
      (rdStatus && !hit[i]) |=> !flag[i]);
    // R9: a status write never raises a flag
    p_write_no_set_r9: assert property (@(posedge clk) disable iff (!rstN)
      (wrStatus && !hit[i] && !flag[i]) |=> !flag[i]);
  end

  assign cntEn  = runOn;
  assign cntSrc = srcBits[1] ? SRC_SLOW : (srcBits[0] ? SRC_CASCADE : SRC_DIV2);

  always_comb begin
    busRdata = '0;
    if (busRd) begin
      unique case (busAddr)
        OFS_STATUS: begin
          busRdata[0]           = runOn;
          busRdata[NUM_MATCH:1] = flag;
        end
        OFS_CNTHI: busRdata[DATA_W-1 -: HI_W] = cntHi;
        OFS_CNTLO: busRdata = cntSnap;
        default:   busRdata = '0;
      endcase
    end
  end

  assign irqReq   = (|prio) && (|(flag & intEn));
  assign irqLevel = prio;

  // R12: no request without a raised flag
  p_irq_needs_flag_r12: assert property (@(posedge clk) disable iff (!rstN)
    !(|flag) |-> !irqReq);
endmodule

// File: rtl/dual_match_timer.sv
`timescale 1ns/1ps
module dual_match_timer
  import tmr_pkg::*;
#(
  parameter int CNT_W  = 10,
  parameter int DATA_W = 8,
  parameter int PRE_W  = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [BUS_AW-1:0] busAddr,
  input  logic              busWr,
  input  logic              busRd,
  input  logic [DATA_W-1:0] busWdata,
  output logic [DATA_W-1:0] busRdata,
  input  logic              cascadeTick,
  output logic              irqReq,
  output logic [1:0]        irqLevel
);
  localparam int HI_W = CNT_W - DATA_W;

  dpStrb_t              strb;
  logic                 cntEn;
  cntSrc_t              cntSrc;
  logic [NUM_MATCH-1:0] hit;
  logic [HI_W-1:0]      cntHi;
  logic [DATA_W-1:0]    cntSnap;

  tmr_ctrl #(.CNT_W(CNT_W), .DATA_W(DATA_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWr(busWr), .busRd(busRd),
    .busWdata(busWdata), .hit(hit), .cntHi(cntHi), .cntSnap(cntSnap),
    .strb(strb), .cntEn(cntEn), .cntSrc(cntSrc), .busRdata(busRdata),
    .irqReq(irqReq), .irqLevel(irqLevel)
  );

  tmr_datapath #(.CNT_W(CNT_W), .DATA_W(DATA_W), .PRE_W(PRE_W)) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .busWdata(busWdata), .cntEn(cntEn),
    .cntSrc(cntSrc), .cascadeTick(cascadeTick), .hit(hit), .cntHi(cntHi),
    .cntSnap(cntSnap)
  );
endmodule

// File: tb/sim_dual_match_timer.sv
`timescale 1ns/1ps
module sim_dual_match_timer;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [3:0] busAddr = '0;
  logic       busWr = 1'b0;
  logic       busRd = 1'b0;
  logic [7:0] busWdata = '0;
  logic [7:0] busRdata;
  logic       cascadeTick = 1'b0;
  logic       irqReq;
  logic [1:0] irqLevel;

  int checks = 0;
  int fails  = 0;
  string curReq = "R1";

  always #5 clk = ~clk;

  dual_match_timer u0 (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWr(busWr), .busRd(busRd),
    .busWdata(busWdata), .busRdata(busRdata), .cascadeTick(cascadeTick),
    .irqReq(irqReq), .irqLevel(irqLevel)
  );

  // behavioural reference model
  int mCnt, mPre, mEn, mIe1, mIe2, mF1, mF2, mSrc, mPrio;
  int mHi1, mHi2, mTgt1, mTgt2, mSnap;
  int tk, nc;

  always @(posedge clk) begin
    if (!rstN) begin
      mCnt = 0; mPre = 0; mEn = 0; mIe1 = 0; mIe2 = 0; mF1 = 0; mF2 = 0;
      mSrc = 0; mPrio = 0; mHi1 = 0; mHi2 = 0; mTgt1 = 0; mTgt2 = 0; mSnap = 0;
    end else begin
      tk = 0;
      if (mEn != 0) begin
        if (mSrc >= 2)      tk = (mPre == 15) ? 1 : 0;
        else if (mSrc == 1) tk = cascadeTick ? 1 : 0;
        else                tk = (mPre % 2 == 1) ? 1 : 0;
      end
      nc = (tk != 0) ? (mCnt + 1) % 1024 : mCnt;
      if (busRd && busAddr == 4'h0) begin mF1 = 0; mF2 = 0; end
      if (tk != 0 && nc == mTgt1) mF1 = 1;
      if (tk != 0 && nc == mTgt2) mF2 = 1;
      if (busRd && busAddr == 4'hE) mSnap = mCnt % 256;
      mPre = (mEn != 0) ? (mPre + 1) % 16 : 0;
      mCnt = nc;
      if (busWr) begin
        case (busAddr)
          4'h0: begin mEn = busWdata[0]; mIe1 = busWdata[1]; mIe2 = busWdata[2]; end
          4'h1: begin mSrc = busWdata[3:2]; mPrio = busWdata[1:0]; end
          4'h2: mHi1 = busWdata[7:6];
          4'h3: mTgt1 = mHi1 * 256 + busWdata;
          4'h4: mHi2 = busWdata[7:6];
          4'h5: mTgt2 = mHi2 * 256 + busWdata;
          default: ;
        endcase
      end
    end
  end

  function automatic int expRd();
    if (!busRd) return 0;
    case (busAddr)
      4'h0: return mEn + 2 * mF1 + 4 * mF2;
      4'hE: return (mCnt / 256) * 64;
      4'hF: return mSnap;
      default: return 0;
    endcase
  endfunction

  task automatic chk(input int act, input int exp, input string req, input string what);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // one clock; compare with the model at the falling edge
  task automatic cyc();
    int expIrq;
    @(negedge clk);
    expIrq = (mPrio != 0 && ((mF1 != 0 && mIe1 != 0) || (mF2 != 0 && mIe2 != 0))) ? 1 : 0;
    chk(int'(busRdata), expRd(), curReq, "model rdata");
    chk(int'(irqReq), expIrq, curReq, "model irqReq");
    chk(int'(irqLevel), mPrio, curReq, "model irqLevel");
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) cyc();
  endtask

  task automatic wr(input int a, input int d);
    busAddr = 4'(a); busWdata = 8'(d); busWr = 1'b1;
    cyc();
    busWr = 1'b0;
  endtask

  task automatic rd(input int a, output int v);
    busAddr = 4'(a); busRd = 1'b1;
    #1 v = busRdata;
    cyc();
    busRd = 1'b0;
  endtask

  task automatic readCount(output int v);
    int h, l;
    rd(14, h); rd(15, l);
    v = (h / 64) * 256 + l;
  endtask

  task automatic pulses(input int n);
    cascadeTick = 1'b1;
    idle(n);
    cascadeTick = 1'b0;
  endtask

  initial begin
    #1_000_000;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", checks, fails);
    $finish;
  end

  initial begin
    int v, c0, c1;
    repeat (3) @(negedge clk);
    rstN = 1'b1;

    curReq = "R1";
    rd(0, v);  chk(v, 0, "R1", "status after reset");
    rd(14, v); chk(v, 0, "R1", "count high after reset");
    rd(15, v); chk(v, 0, "R1", "count low after reset");
    chk(int'(irqReq), 0, "R1", "irqReq after reset");

    wr(2, 0); wr(3, 5); wr(4, 0); wr(5, 10);

    curReq = "R2";
    idle(10);
    readCount(v); chk(v, 0, "R2", "count while disabled");

    curReq = "R3";
    wr(1, 8'h00); wr(0, 8'h01);
    readCount(c0); idle(18); readCount(c1);
    chk(c1 - c0, 10, "R3", "div2 ticks in 20 cycles");

    curReq = "R7";
    rd(0, v); chk(v, 7, "R7", "both flags after passing targets");
    curReq = "R8";
    rd(0, v); chk(v, 1, "R8", "flags cleared by read");

    curReq = "R9";
    wr(0, 8'h07); idle(3);
    rd(0, v); chk(v, 1, "R9", "enable write does not set flags");
    chk(int'(irqReq), 0, "R9", "no request without flags");

    curReq = "R12";
    wr(1, 8'h02);
    readCount(c0);
    wr(2, ((c0 + 8) / 256) * 64); wr(3, (c0 + 8) % 256);
    idle(20);
    chk(int'(irqReq), 1, "R12", "request with flag, enable, prio 2");
    chk(int'(irqLevel), 2, "R12", "level follows prio");
    wr(1, 8'h00);
    chk(int'(irqReq), 0, "R12", "prio 0 silences request");
    wr(1, 8'h02);
    chk(int'(irqReq), 1, "R12", "request returns with prio");
    rd(0, v);
    chk(int'(irqReq), 0, "R12", "request drops after clear");

    curReq = "R10";
    wr(1, 8'h04);                 // cascade source, prio 0
    wr(2, 8'h40); wr(3, 8'h03);   // target 1 = 259
    wr(4, 8'h80);                 // pending only, target 2 stays 10
    readCount(c0);
    pulses(258 - c0);
    rd(0, v); chk(v & 2, 0, "R10", "no flag one short of 259");
    pulses(1);
    rd(0, v); chk(v, 3, "R10", "flag at committed target 259");

    curReq = "R6";
    pulses(764);
    readCount(v); chk(v, 1023, "R6", "count at top");
    pulses(1);
    readCount(v); chk(v, 0, "R6", "wrap to zero");
    rd(0, v);
    pulses(10);
    rd(0, v); chk(v & 4, 4, "R10", "pending high bits left target 2 at 10");

    curReq = "R4";
    readCount(c0);
    for (int i = 0; i < 7; i++) begin pulses(1); idle(2); end
    readCount(c1); chk(c1 - c0, 7, "R4", "one step per cascade pulse");

    curReq = "R5";
    wr(1, 8'h08);
    readCount(c0); idle(62); readCount(c1);
    chk(c1 - c0, 4, "R5", "slow ticks in 64 cycles");
    wr(1, 8'h0C);
    readCount(c0); idle(30); readCount(c1);
    chk(c1 - c0, 2, "R5", "code 11 also slow");

    curReq = "R2";
    wr(0, 8'h00);
    readCount(c0); idle(40); readCount(c1);
    chk(c1, c0, "R2", "frozen while disabled");

    curReq = "R13";
    wr(1, 8'h0F);
    rd(1, v); chk(v, 0, "R13", "control reads zero");
    rd(2, v); chk(v, 0, "R13", "target high reads zero");
    rd(7, v); chk(v, 0, "R13", "unassigned reads zero");
    busAddr = 4'h0; #1 chk(int'(busRdata), 0, "R13", "no read strobe gives zero");
    idle(1);

    curReq = "R11";
    wr(1, 8'h04); wr(0, 8'h01);
    pulses(300);
    rd(14, c0);
    pulses(5);
    rd(15, v);
    chk(v, mSnap, "R11", "low returns capture, not live count");
    chk(v == (mCnt % 256) ? 1 : 0, 0, "R11", "capture differs from moved count");

    curReq = "R8";
    readCount(c0);
    wr(2, ((c0 + 1) / 256) * 64); wr(3, (c0 + 1) % 256);
    busAddr = 4'h0; busRd = 1'b1; cascadeTick = 1'b1;
    cyc();
    busRd = 1'b0; cascadeTick = 1'b0;
    rd(0, v); chk(v & 2, 2, "R8", "match wins over coincident read");

    idle(4);
    $display("  [TB] %0d tests run, %0d failed", checks, fails);
    $finish;
  end
endmodule